// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame is kept, using only its 48-bit destination address. The address arrives one byte per accepted cycle, first byte first, with a strobe on the first byte. As each byte arrives, the block updates a running CRC-32 over the address bits. After the sixth byte it takes the final CRC, forms a 6-bit index from its low bits, and uses that index to pick one bit of a 64-bit hash table. Software fills the table through four 16-bit registers.

The accept rule depends on the kind of address. In promiscuous mode every frame is kept. The all-ones broadcast address is always kept. A multicast address is one whose first byte has bit 0 set. It is kept when all-multicast mode is on or when its hash bit is set. A unicast address is kept only when it matches the programmed station address exactly. The result appears as a one-cycle valid pulse together with the accept flag.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset, decision_valid_o and accept_o are 0 and all 64 table bits are 0. With both modes off, a non-broadcast multicast address is then rejected.
- R2: decision_valid_o pulses high for one cycle in the cycle that follows the clock edge sampling the sixth address byte. Cycles with byte_valid_i low are skipped. Bytes that arrive after the sixth and before the next start are ignored. accept_o is 0 whenever decision_valid_o is 0.
- R3: The hash uses CRC-32 with the reflected polynomial 0xEDB88320. The register starts at all ones and is not inverted at the end. Address bits enter least significant bit first, byte 0 first, for 48 bit steps.
- R4: The table index takes CRC bit 0 as index bit 5, CRC bit 1 as index bit 4, and so on up to CRC bit 5 as index bit 0. The index selects table byte index>>3 and bit index&7 within that byte.
- R5: Table register k (selected by tbl_sel_i = k and written on a cycle with tbl_wr_i high) holds table byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Table bit i is therefore bit i%16 of register i/16. A write affects decisions made from the next cycle on.
- R6: An address is multicast when bit 0 of its first byte (address bits 7:0 hold the first byte) is 1. Only multicast addresses use all-multicast mode or the hash table.
- R7: When promisc_i is 1 at the sixth byte, the frame is accepted whatever its address.
- R8: When allmulti_i is 1 at the sixth byte, every multicast address is accepted, whatever the table holds.
- R9: The broadcast address (all 48 bits set) is accepted in every mode and with any table contents.
- R10: A unicast address is accepted only when all 48 bits equal station_addr_i, with bits 7:0 compared against the first byte. A difference in one bit rejects it.
- R11: A start strobe that arrives partway through an address abandons the partial address and begins a new one from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the first address byte (meaningful with byte_valid_i) |
| byte_valid_i | input | 1 | byte_i carries an address byte this cycle |
| byte_i | input | 8 | Destination address byte |
| promisc_i | input | 1 | Accept all frames |
| allmulti_i | input | 1 | Accept all multicast frames |
| station_addr_i | input | 48 | Station address, bits 7:0 are the first byte |
| tbl_wr_i | input | 1 | Write strobe for a hash table register |
| tbl_sel_i | input | 2 | Hash table register number |
| tbl_data_i | input | 16 | Hash table register write data |
| decision_valid_o | output | 1 | One-cycle pulse when the decision is ready |
| accept_o | output | 1 | Frame accepted, qualified by decision_valid_o |

## Verification
The bench sets exactly one table bit at the index its own reference computes for each of several multicast addresses, and then sets every bit except that one. A design that reversed the index bits, swapped the halves of a register or inverted the CRC would accept and reject the wrong addresses in these tests. It compares unicast addresses that differ from the station address in a single bit, and it checks the broadcast address against an empty table. It also runs unicast addresses with all-multicast mode on, which catches a design that tests the wrong bit for multicast. Finally it inserts idle gaps inside an address, sends extra bytes after the sixth, and restarts partway through an address; a byte counter that mishandles any of these would move the decision pulse or repeat it.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    crc_bit = {1'b0, c[CRC_W-1:1]} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [mhf_pkg::CRC_W-1:0] crc_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [mhf_pkg::CRC_W-1:0] crc_o
);
  // lsb of the byte enters first
  always_comb begin
    crc_o = crc_i;
    for (int i = 0; i < DATA_W; i++) crc_o = mhf_pkg::crc_bit(crc_o, data_i[i]);
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned REG_W     = 16,
  localparam int unsigned TBL_BITS = 1 << HASH_BITS,
  localparam int unsigned NUM_REGS = TBL_BITS / REG_W,
  localparam int unsigned SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [REG_W-1:0]     data_i,
  input  logic [HASH_BITS-1:0] idx_i,
  output logic                 hit_o
);
  logic [TBL_BITS-1:0] tbl_flat;

  // even byte in low half, so flat bit order equals hash index order
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reg_q <= '0;
      else if (wr_i && (sel_i == SEL_W'(g))) reg_q <= data_i;
    end
    assign tbl_flat[g*REG_W +: REG_W] = reg_q;
  end

  assign hit_o = tbl_flat[idx_i];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide #(
  parameter int unsigned ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic              promisc_i,
  input  logic              allmulti_i,
  input  logic              hit_i,
  output logic              accept_o
);
  logic is_mcast, is_bcast, is_mine;

  assign is_mcast = addr_i[0];
  assign is_bcast = &addr_i;
  assign is_mine  = (addr_i == station_i);

  always_comb begin
    if (promisc_i || is_bcast) accept_o = 1'b1;
    else if (is_mcast)         accept_o = allmulti_i || hit_i;
    else                       accept_o = is_mine;
  end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  parameter int unsigned REG_W      = 16,
  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES,
  localparam int unsigned NUM_REGS  = (1 << HASH_BITS) / REG_W,
  localparam int unsigned SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              promisc_i,
  input  logic              allmulti_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              tbl_wr_i,
  input  logic [SEL_W-1:0]  tbl_sel_i,
  input  logic [REG_W-1:0]  tbl_data_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]          cnt_q, pos;
  logic [mhf_pkg::CRC_W-1:0] crc_q, crc_base, crc_nxt;
  logic [ADDR_W-1:0]         addr_q, addr_nxt;
  logic                      in_frame, take, last;
  logic [HASH_BITS-1:0]      hash_idx;
  logic                      hit, acc_comb;
  logic                      valid_q, accept_q;

  assign in_frame = (cnt_q != '0) && (cnt_q < DONE_CNT);
  assign take     = byte_valid_i && (start_i || in_frame);
  assign pos      = start_i ? '0 : cnt_q;
  assign last     = take && (pos == LAST_POS);
  assign crc_base = start_i ? '1 : crc_q;

  always_comb begin
    addr_nxt = start_i ? '0 : addr_q;
    if (take) addr_nxt[8*pos +: 8] = byte_i;
  end

  mhf_crc_step #(.DATA_W(8)) u_crc (
    .crc_i  (crc_base),
    .data_i (byte_i),
    .crc_o  (crc_nxt)
  );

  // index msb comes from crc bit 0
  for (genvar j = 0; j < HASH_BITS; j++) begin : g_idx
    assign hash_idx[HASH_BITS-1-j] = crc_nxt[j];
  end

  mhf_hash_table #(.HASH_BITS(HASH_BITS), .REG_W(REG_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (tbl_wr_i),
    .sel_i  (tbl_sel_i),
    .data_i (tbl_data_i),
    .idx_i  (hash_idx),
    .hit_o  (hit)
  );

  mhf_decide #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_nxt),
    .station_i  (station_addr_i),
    .promisc_i  (promisc_i),
    .allmulti_i (allmulti_i),
    .hit_i      (hit),
    .accept_o   (acc_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      crc_q    <= '1;
      addr_q   <= '0;
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      if (take) begin
        cnt_q  <= pos + 1'b1;
        crc_q  <= crc_nxt;
        addr_q <= addr_nxt;
      end
      valid_q  <= last;
      accept_q <= last && acc_comb;
    end
  end

  assign decision_valid_o = valid_q;
  assign accept_o         = accept_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_valid_i,
  input logic promisc_i,
  input logic decision_valid_o,
  input logic accept_o
);
  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);

  p_valid_after_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> $past(byte_valid_i));

  p_accept_qualified_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> !accept_o);

  p_promisc_accepts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && $past(promisc_i)) |-> accept_o);

  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!decision_valid_o && !accept_o);
    end
  end
endmodule

bind mcast_addr_filter mhf_checker u_mhf_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .byte_valid_i     (byte_valid_i),
  .promisc_i        (promisc_i),
  .decision_valid_o (decision_valid_o),
  .accept_o         (accept_o)
);

// File: tb/mcast_addr_filter_tb_top.sv
module mcast_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bvalid = 1'b0;
  logic [7:0]  bdat = '0;
  logic        promisc = 1'b0, allmulti = 1'b0;
  logic [47:0] station = 48'hBEEF_CAFE_1202;
  logic        twr = 1'b0;
  logic [1:0]  tsel = '0;
  logic [15:0] tdat = '0;
  logic        dvalid, acc;

  int    n_cmp = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mcast_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_valid_i(bvalid), .byte_i(bdat),
    .promisc_i(promisc), .allmulti_i(allmulti), .station_addr_i(station),
    .tbl_wr_i(twr), .tbl_sel_i(tsel), .tbl_data_i(tdat),
    .decision_valid_o(dvalid), .accept_o(acc)
  );

  // ---------------- reference model ----------------
  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic fb = c[0] ^ a[n];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic int ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    int idx = 0;
    for (int j = 0; j < 6; j++) if (c[j]) idx += (1 << (5 - j));
    return idx;
  endfunction

  logic [63:0] m_tbl;
  logic [47:0] m_addr;
  int          m_cnt;
  logic        m_valid, m_acc;

  function automatic logic ref_accept(input logic [47:0] a);
    if (promisc || a == '1) return 1'b1;
    if (a[0]) return allmulti || m_tbl[ref_idx(a)];
    return a == station;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tbl = '0; m_addr = '0; m_cnt = 0; m_valid = 1'b0; m_acc = 1'b0;
    end else begin
      m_valid = 1'b0; m_acc = 1'b0;
      if (bvalid && (start || (m_cnt > 0 && m_cnt < 6))) begin
        if (start) begin m_addr = '0; m_cnt = 0; end
        m_addr[8*m_cnt +: 8] = bdat;
        m_cnt++;
        if (m_cnt == 6) begin m_valid = 1'b1; m_acc = ref_accept(m_addr); end
      end
      if (twr) m_tbl[16*tsel +: 16] = tdat;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (dvalid !== m_valid || acc !== m_acc) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual valid=%b acc=%b expected valid=%b acc=%b",
                 cur_req, dvalid, acc, m_valid, m_acc);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int k, input logic [15:0] d);
    @(negedge clk); twr = 1'b1; tsel = 2'(k); tdat = d;
    @(negedge clk); twr = 1'b0;
  endtask

  task automatic clr_tbl();
    for (int k = 0; k < 4; k++) wr_tbl(k, 16'h0000);
  endtask

  task automatic send_addr(input logic [47:0] a, input bit gaps);
    for (int n = 0; n < 6; n++) begin
      if (gaps && (n == 2 || n == 5)) begin
        @(negedge clk); bvalid = 1'b0; start = 1'b0; bdat = 8'hA5;
      end
      @(negedge clk); bvalid = 1'b1; start = (n == 0); bdat = a[8*n +: 8];
    end
    @(negedge clk); bvalid = 1'b0; start = 1'b0;
  endtask

  task automatic send_chk(input string req, input logic [47:0] a, input bit gaps, input logic exp);
    cur_req = req;
    send_addr(a, gaps);
    chk(req, dvalid, 1'b1);
    chk(req, acc, exp);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [47:0] a;
    logic [31:0] lcg;
    int i;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", dvalid, 1'b0);
    chk("R1 reset accept", acc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    send_chk("R1", 48'h0000_0000_0001, 1'b0, 1'b0);
    send_chk("R10", station, 1'b0, 1'b1);
    send_chk("R10", station ^ 48'h0100_0000_0000, 1'b0, 1'b0);
    send_chk("R9", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1);

    lcg = 32'h1234_5678;
    for (int t = 0; t < 10; t++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = {lcg, lcg[15:0]};
      a[0] = 1'b1;
      a[47] = 1'b0;
      i = ref_idx(a);
      clr_tbl();
      wr_tbl(i / 16, 16'(1) << (i % 16));
      send_chk("R4 R5 single bit set", a, t[0], 1'b1);
      for (int k = 0; k < 4; k++)
        wr_tbl(k, (k == i / 16) ? ~(16'(1) << (i % 16)) : 16'hFFFF);
      send_chk("R3 R4 all but own bit", a, 1'b0, 1'b0);
      send_chk("R9 broadcast full table", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1);
    end
    clr_tbl();

    allmulti = 1'b1;
    send_chk("R8", 48'h0A0B_0C0D_0E0F, 1'b0, 1'b1);
    send_chk("R6 unicast under allmulti", 48'h0A0B_0C0D_0E10, 1'b0, 1'b0);
    send_chk("R6 station under allmulti", station, 1'b0, 1'b1);
    allmulti = 1'b0;

    promisc = 1'b1;
    send_chk("R7 unicast", 48'h1111_2222_3334, 1'b0, 1'b1);
    send_chk("R7 multicast", 48'h1111_2222_3335, 1'b0, 1'b1);
    promisc = 1'b0;

    send_chk("R2 gaps", station, 1'b1, 1'b1);
    cur_req = "R2 trailing bytes";
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); bvalid = 1'b1; start = 1'b0; bdat = station[7:0];
      chk("R2 no valid on trailing byte", dvalid, 1'b0);
    end
    @(negedge clk); bvalid = 1'b0;
    chk("R2 no valid after trailing bytes", dvalid, 1'b0);

    cur_req = "R11";
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); bvalid = 1'b1; start = (n == 0); bdat = 8'h77;
    end
    send_chk("R11 restart", station, 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_fail++;
      $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule